// File: doc/BRIEF.md
# NAND Page Copy Engine

This block moves a contiguous run of pages out of a raw NAND flash and into an on-chip RAM. A single start pulse triggers the copy. The block reads page after page. For each page it lowers chip enable and issues the read command under the command-latch line. It then sends a column byte and two row bytes under the address-latch line and waits for the flash to report ready. Finally it streams the whole page straight into a synchronous RAM write port, at rising addresses from a chosen base. When the run is complete, a done flag stays high until the next start pulse.

Every page gets a complete command, address and busy-wait sequence of its own. The read is never left to run linearly across a page boundary, because the flash would wander into its spare area if it did. The parameter `BUS_W` selects an 8-bit or a 16-bit flash. In 16-bit mode the source byte offset is halved into a word offset, and a page is 256 word reads. In 8-bit mode a page is 512 byte reads. In both modes one page stands for 512 bytes of the byte count.

The controller is a single state machine:

| State | Role |
|---|---|
| `S_IDLE` | Waits for start. |
| `S_CMD` | Command write. |
| `S_CMD_HOLD` | Command-latch settle. |
| `S_COL` | Column byte write. |
| `S_ROW_LO` | First row byte write. |
| `S_ROW_HI` | Second row byte write. |
| `S_ADR_HOLD` | Address-latch settle. |
| `S_BUSY_WAIT` | Polls ready/busy. |
| `S_XFER` | One read per cycle into RAM. |
| `S_ADVANCE` | Page bookkeeping. |

The transitions are:
- start taken: `S_IDLE` to `S_CMD`.
- always: `S_CMD` to `S_CMD_HOLD`.
- settle timer expired: `S_CMD_HOLD` to `S_COL`.
- always, in order: `S_COL` to `S_ROW_LO` to `S_ROW_HI` to `S_ADR_HOLD`.
- settle timer expired: `S_ADR_HOLD` to `S_BUSY_WAIT`.
- ready/busy high: `S_BUSY_WAIT` to `S_XFER`.
- last transfer of the page: `S_XFER` to `S_ADVANCE`.
- more pages left: `S_ADVANCE` to `S_CMD`.
- otherwise: `S_ADVANCE` to `S_IDLE`, with done set.

Top module: `nand_page_copier`

## Requirements
- R1: While reset is held and afterwards until a start pulse, `nand_ce_n` is 1 and `nand_cle`, `nand_ale`, `nand_wr`, `nand_rd`, `ram_we` and `done` are 0.
- R2: Each page opens with a single cycle in which `nand_ce_n`=0, `nand_cle`=1, `nand_wr`=1 and `nand_dout`=0x00 (the read command). `nand_cle` then remains high for another `SETTLE` cycles (20 by default) with no write strobe.
- R3: The address phase runs `nand_ale` high for three consecutive write-strobe cycles, the first of which carries column byte 0x00. `nand_ale` then remains high for another `SETTLE` cycles and falls.
- R4: When `nand_ale` has fallen, the block sits with chip enable low and no read strobe for as long as `nand_rb` is 0. It leaves that wait in the cycle after the first cycle in which `nand_rb` is 1.
- R5: Each page consists of `PAGE_XFERS` consecutive read cycles (256 when `BUS_W`=16, 512 when 8). In each of these cycles `ram_we`=1 and `ram_wdata` equals `nand_din`. `ram_addr` begins at `dst_base` and rises by `BUS_W`/8 on every write, across pages as well as within them.
- R6: The second and third address bytes carry bits [15:8] and then bits [23:16] of the flash offset. With `BUS_W`=16 the offset for the first page is `src_off` shifted right by one.
- R7: After every page the flash offset grows by `PAGE_XFERS` and the remaining count falls by 512. Another page follows as long as the remaining count is still zero or above, so a count C copies floor(C/512)+1 pages. Each page ends with a single bookkeeping cycle in which chip enable is low and all strobes are low.
- R8: In the cycle after the last bookkeeping cycle, `done` rises and every flash line goes idle (`nand_ce_n`=1). This state holds until the next start pulse.
- R9: A start pulse that arrives while a copy is running, in any state including the final bookkeeping cycle, is ignored. The sequence and the latched base, offset and count do not change.
- R10: A start pulse taken in idle clears `done` and begins the command cycle on the next clock, whether or not a previous copy has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, only acted on in idle |
| dst_base | input | ADDR_W | RAM byte address of the first write |
| src_off | input | OFF_W | Flash source byte offset |
| byte_cnt | input | CNT_W | Byte count that sets the page count |
| done | output | 1 | High after a copy completes, until next start |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wr | output | 1 | Write strobe for command and address bytes |
| nand_rd | output | 1 | Read strobe, one data transfer per cycle |
| nand_dout | output | BUS_W | Command/address byte to the flash, zero otherwise |
| nand_din | input | BUS_W | Read data from the flash |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | BUS_W | RAM write data |

## Verification
Two things can fall in the same cycle: a fresh start pulse, and the page-advance decision that either loops back to another command or ends the copy. The bench places a start pulse exactly on the final bookkeeping cycle of a three-page run, and another inside the busy wait of the first page. At both pulses it offers different base, offset and count values. The behavioural reference expects the engine to fall idle with `done` high on the very next cycle, without launching a new command and without any trace of the offered values. Each clock it compares every flash line and RAM port output with the reference's own per-cycle expectations.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_CMD_HOLD,
        S_COL,
        S_ROW_LO,
        S_ROW_HI,
        S_ADR_HOLD,
        S_BUSY_WAIT,
        S_XFER,
        S_ADVANCE
    } npc_state_e;

    localparam logic [7:0] NPC_READ_CMD = 8'h00;
    localparam int         NPC_PAGE_BYTES = 512;

endpackage

// File: rtl/npc_settle_timer.sv
module npc_settle_timer #(
    parameter int SETTLE = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2 R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

endmodule

// File: rtl/npc_cursor.sv
module npc_cursor #(
    parameter int BUS_W      = 16,
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 24,
    parameter int CNT_W      = 16,
    parameter int PAGE_XFERS = 256,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_xfer,
    input  logic              step_page,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [OFF_W-1:0]  flash_off,
    output logic              more_pages,
    output logic              xfer_last
);
    localparam int IW = $clog2(PAGE_XFERS);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BUS_W / 8);
    localparam logic [OFF_W-1:0]  OFF_STEP  = OFF_W'(PAGE_XFERS);
    localparam logic [CNT_W:0]    CNT_STEP  = (CNT_W+1)'(PAGE_BYTES);
    localparam logic [IW-1:0]     LAST_IDX  = IW'(PAGE_XFERS - 1);

    logic [OFF_W-1:0] start_off;
    logic [CNT_W:0]   remain;
    logic [CNT_W:0]   remain_nx;
    logic [IW-1:0]    idx;

    generate
        if (BUS_W == 16) begin : g_word
            assign start_off = src_off >> 1;
        end else begin : g_byte
            assign start_off = src_off;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr  <= '0;
            flash_off <= '0;
            remain    <= '0;
            idx       <= '0;
        end else if (load) begin
            ram_addr  <= dst_base;
            flash_off <= start_off;
            remain    <= {1'b0, byte_cnt};
            idx       <= '0;
        end else begin
            if (step_xfer) begin
                ram_addr <= ram_addr + ADDR_STEP;
                idx      <= idx + 1'b1;
            end
            if (step_page) begin
                flash_off <= flash_off + OFF_STEP;
                remain    <= remain_nx;
                idx       <= '0;
            end
        end
    end

    assign remain_nx  = remain - CNT_STEP;
    assign more_pages = ~remain_nx[CNT_W];
    assign xfer_last  = (idx == LAST_IDX);

    // R5
    ram_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_xfer && !xfer_last) |=> (ram_addr == $past(ram_addr) + ADDR_STEP));

endmodule

// File: rtl/nand_page_copier.sv
module nand_page_copier
    import npc_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 24,
    parameter int CNT_W  = 16,
    parameter int SETTLE = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic              done,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wr,
    output logic              nand_rd,
    output logic [BUS_W-1:0]  nand_dout,
    input  logic [BUS_W-1:0]  nand_din,
    input  logic              nand_rb,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BUS_W-1:0]  ram_wdata
);
    localparam int PAGE_XFERS = (BUS_W == 16) ? 256 : 512;

    npc_state_e       state, state_nx;
    logic             done_q;
    logic             settle_load, settled;
    logic             more_pages, xfer_last;
    logic [OFF_W-1:0] flash_off;
    logic             take_start;

    assign take_start  = (state == S_IDLE) && start;
    assign settle_load = (state == S_CMD) || (state == S_ROW_HI);

    npc_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settled)
    );

    npc_cursor #(
        .BUS_W      (BUS_W),
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .CNT_W      (CNT_W),
        .PAGE_XFERS (PAGE_XFERS),
        .PAGE_BYTES (NPC_PAGE_BYTES)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_start),
        .step_xfer  (state == S_XFER),
        .step_page  (state == S_ADVANCE),
        .dst_base   (dst_base),
        .src_off    (src_off),
        .byte_cnt   (byte_cnt),
        .ram_addr   (ram_addr),
        .flash_off  (flash_off),
        .more_pages (more_pages),
        .xfer_last  (xfer_last)
    );

    // state register and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            done_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_start) begin
                done_q <= 1'b0;
            end else if (state == S_ADVANCE && !more_pages) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start) state_nx = S_CMD;
            S_CMD:       state_nx = S_CMD_HOLD;
            S_CMD_HOLD:  if (settled) state_nx = S_COL;
            S_COL:       state_nx = S_ROW_LO;
            S_ROW_LO:    state_nx = S_ROW_HI;
            S_ROW_HI:    state_nx = S_ADR_HOLD;
            S_ADR_HOLD:  if (settled) state_nx = S_BUSY_WAIT;
            S_BUSY_WAIT: if (nand_rb) state_nx = S_XFER;
            S_XFER:      if (xfer_last) state_nx = S_ADVANCE;
            S_ADVANCE:   state_nx = more_pages ? S_CMD : S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        nand_ce_n = 1'b0;
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        nand_wr   = 1'b0;
        nand_rd   = 1'b0;
        nand_dout = '0;
        ram_we    = 1'b0;
        unique case (state)
            S_IDLE:      nand_ce_n = 1'b1;
            S_CMD: begin
                nand_cle  = 1'b1;
                nand_wr   = 1'b1;
                nand_dout = BUS_W'(NPC_READ_CMD);
            end
            S_CMD_HOLD:  nand_cle = 1'b1;
            S_COL: begin
                nand_ale = 1'b1;
                nand_wr  = 1'b1;
            end
            S_ROW_LO: begin
                nand_ale  = 1'b1;
                nand_wr   = 1'b1;
                nand_dout = BUS_W'(flash_off[15:8]);
            end
            S_ROW_HI: begin
                nand_ale  = 1'b1;
                nand_wr   = 1'b1;
                nand_dout = BUS_W'(flash_off[23:16]);
            end
            S_ADR_HOLD:  nand_ale = 1'b1;
            S_BUSY_WAIT: ;
            S_XFER: begin
                nand_rd = 1'b1;
                ram_we  = 1'b1;
            end
            S_ADVANCE:   ;
            default:     nand_ce_n = 1'b1;
        endcase
    end

    assign done      = done_q;
    assign ram_wdata = nand_din;

    // R2
    cmd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_cle) |-> (nand_wr && !nand_ce_n && nand_dout == '0));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY_WAIT && !nand_rb) |=> (!nand_rd && !ram_we));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nand_ce_n && !nand_cle && !nand_ale && !nand_rd && !ram_we));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER && start) |=> !nand_wr);

endmodule

// File: tb/nand_page_copier_test.sv
`timescale 1ns/1ps
module nand_page_copier_test;

    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dst_base = '0;
    logic [23:0] src_off = '0;
    logic [15:0] byte_cnt = '0;
    logic        done, nand_ce_n, nand_cle, nand_ale, nand_wr, nand_rd;
    logic [15:0] nand_dout;
    logic [15:0] nand_din = '0;
    logic        nand_rb = 1'b1;
    logic        ram_we;
    logic [15:0] ram_addr, ram_wdata;

    always #10 clk = ~clk;

    nand_page_copier uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dst_base(dst_base), .src_off(src_off), .byte_cnt(byte_cnt),
        .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_wr(nand_wr), .nand_rd(nand_rd),
        .nand_dout(nand_dout), .nand_din(nand_din), .nand_rb(nand_rb),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    typedef struct {
        logic        start;
        logic        rb;
        logic [15:0] din;
        logic [15:0] dst;
        logic [23:0] off;
        logic [15:0] cnt;
        logic        ce_n, cle, ale, wr, rd, we, done;
        logic [15:0] dout, waddr, wdata;
        string       tag;
    } ent_t;

    ent_t        q[$];
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic        exp_done = 1'b0;
    logic [15:0] cur_dst = '0;
    logic [23:0] cur_off = '0;
    logic [15:0] cur_cnt = '0;

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic ent_t idle_ent(input string tag);
        ent_t e;
        e.start = 1'b0; e.rb = 1'b1; e.din = '0;
        e.dst = cur_dst; e.off = cur_off; e.cnt = cur_cnt;
        e.ce_n = 1'b1; e.cle = 1'b0; e.ale = 1'b0; e.wr = 1'b0;
        e.rd = 1'b0; e.we = 1'b0; e.done = exp_done;
        e.dout = '0; e.waddr = '0; e.wdata = '0;
        e.tag = tag;
        return e;
    endfunction

    function automatic ent_t busy_ent(input string tag);
        ent_t e;
        e = idle_ent(tag);
        e.ce_n = 1'b0;
        return e;
    endfunction

    task automatic plan_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) q.push_back(idle_ent(tag));
    endtask

    // stray start with unrelated inputs, must be ignored (R9)
    function automatic ent_t poke(input ent_t e);
        ent_t p;
        p = e;
        p.start = 1'b1; p.dst = 16'hBEEF; p.off = 24'hABCDEF; p.cnt = 16'h7777;
        p.tag = "R9";
        return p;
    endfunction

    task automatic plan_copy(input logic [15:0] d, input logic [23:0] s,
                             input int c, input int busy, input bit pokes);
        ent_t        e;
        logic [23:0] w;
        logic [15:0] a;
        int          rem;
        bit          first;
        cur_dst = d; cur_off = s; cur_cnt = 16'(c);
        e = idle_ent("R10");
        e.start = 1'b1;
        q.push_back(e);
        exp_done = 1'b0;
        w = s >> 1;         // R6 word offset
        a = d;
        rem = c;
        first = 1;
        do begin
            e = busy_ent("R2"); e.cle = 1'b1; e.wr = 1'b1; q.push_back(e);
            for (int i = 0; i < SETTLE; i++) begin
                e = busy_ent("R2"); e.cle = 1'b1; q.push_back(e);
            end
            e = busy_ent("R3"); e.ale = 1'b1; e.wr = 1'b1; q.push_back(e);
            e = busy_ent("R6"); e.ale = 1'b1; e.wr = 1'b1;
            e.dout = {8'h00, w[15:8]}; q.push_back(e);
            e = busy_ent("R6"); e.ale = 1'b1; e.wr = 1'b1;
            e.dout = {8'h00, w[23:16]}; q.push_back(e);
            for (int i = 0; i < SETTLE; i++) begin
                e = busy_ent("R3"); e.ale = 1'b1; q.push_back(e);
            end
            for (int i = 0; i < busy; i++) begin
                e = busy_ent("R4"); e.rb = 1'b0;
                if (pokes && first && i == 0) e = poke(e);
                q.push_back(e);
            end
            q.push_back(busy_ent("R4"));
            for (int i = 0; i < 256; i++) begin
                e = busy_ent("R5"); e.rd = 1'b1; e.we = 1'b1;
                e.din = 16'(w + 24'(i)) ^ 16'hC35A;
                e.waddr = a; e.wdata = e.din;
                q.push_back(e);
                a = a + 16'd2;
            end
            rem = rem - 512;
            w = w + 24'd256;
            e = busy_ent("R7");
            if (pokes && rem < 0) e = poke(e);
            q.push_back(e);
            first = 0;
        end while (rem >= 0);
        exp_done = 1'b1;
    endtask

    task automatic run_queue();
        ent_t e;
        while (q.size() > 0) begin
            e = q.pop_front();
            @(negedge clk);
            start = e.start; nand_rb = e.rb; nand_din = e.din;
            dst_base = e.dst; src_off = e.off; byte_cnt = e.cnt;
            #1;
            cmp(e.tag, "ce_n", nand_ce_n, e.ce_n);
            cmp(e.tag, "cle", nand_cle, e.cle);
            cmp(e.tag, "ale", nand_ale, e.ale);
            cmp(e.tag, "wr", nand_wr, e.wr);
            cmp(e.tag, "dout", nand_dout, e.dout);
            cmp(e.tag, "rd", nand_rd, e.rd);
            cmp(e.tag, "ram_we", ram_we, e.we);
            cmp(e.tag, "done", done, e.done);
            if (e.we) begin
                cmp(e.tag, "ram_addr", ram_addr, e.waddr);
                cmp(e.tag, "ram_wdata", ram_wdata, e.wdata);
            end
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            cmp("R1", "ce_n", nand_ce_n, 1'b1);
            cmp("R1", "strobes", {nand_cle, nand_ale, nand_wr, nand_rd, ram_we}, 5'b0);
            cmp("R1", "done", done, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        plan_idle(3, "R1");
        // one page: count 0, R7 floor(0/512)+1
        plan_copy(16'h0100, 24'h123400, 0, 3, 0);
        plan_idle(4, "R8");
        // two pages: count on page boundary, row byte carry, zero busy
        plan_copy(16'h8000, 24'hFFFE00, 512, 0, 0);
        plan_idle(3, "R8");
        // three pages with stray start pulses in the wait and final advance
        plan_copy(16'h0040, 24'h000200, 1100, 5, 1);
        plan_idle(5, "R8");
        run_queue();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule